// File: doc/BRIEF.md
# Preloadable Up/Down Counter Unit

This block is one channel of a position-counting datapath. A direction decoder ahead of it turns encoder or pulse-train inputs into single-cycle up and down strobes. The unit accumulates those strobes in a 16-bit counter. Software can stage a preload value, and the unit copies it into the counter when the load pin falls or when a load command arrives. The counter value can be captured into a hold register when the latch pin rises or when a latch command arrives.

Clearing has two styles. Edge style clears on a rising edge of the clear pin. Index style clears when the clear pin is high, the second phase is low and the first phase changes, and only with quadrature input. A two-bit policy gates both styles. The unit keeps sticky event flags, which software resets by writing ones. It also keeps load-done and latch-done flags, which drop when status is read.

Two units can form a 32-bit counter. The lower unit's carry and borrow outputs feed the cascade inputs of the upper unit. With cascade selected, the upper unit counts those inputs instead of its own strobes.

Top module: `updown_unit`

## Requirements
- R1: After reset, count and latch_q are 0000h, evt_flags is 0, and ld_done and lt_done are 0.
- R2: Each cycle with an up step and no down step adds 1 to count, modulo 2^16. Each cycle with a down step and no up step subtracts 1. A cycle with both steps, or with neither, leaves count unchanged. The step sources are casc_up_in/casc_dn_in when casc_en is 1, and cnt_up/cnt_dn otherwise.
- R3: carry_out is high, in the same cycle, when an up step is applied at count FFFFh. borrow_out is high, in the same cycle, when a down step is applied at 0000h. Neither is high when that step is overridden by a clear or a load.
- R4: The stored preload value (written by preload_wr) is copied into count on the cycle where ld_pin is seen falling while ld_pin_en is 1, and on any cycle with sw_load. With ld_pin_en at 0, a falling ld_pin loads nothing.
- R5: count, as it stood before that cycle's update, is copied into latch_q on the cycle where lt_pin is seen rising while lt_pin_en is 1, and on any cycle with sw_latch. With lt_pin_en at 0, the pin has no effect.
- R6: When clr_sync is 0, a rising edge of clr_pin is a clear event. Holding clr_pin high does not clear again.
- R7: When clr_sync is 1, a clear event needs all of the following in one cycle: quad_mode is 1, clr_pin is 1, ph1 is 0, and ph0 differs from its previous sample. A bare rising edge of clr_pin is not a clear event in this mode.
- R8: clr_policy decides which clear events set count to 0000h. Codes 00 and 01 allow none. Code 11 allows every one. Code 10 allows one, then ignores further events until policy_wr pulses.
- R9: When events coincide in one cycle, clear wins over load and load wins over a step.
- R10: The evt_flags bits are sticky. Bit 0 records a load, bit 1 a latch, bit 2 a performed clear, and bit 3 an abn_evt pulse. Writing 1 to the same bit of evt_rst clears that flag. A new event in the same cycle keeps the flag set.
- R11: ld_done is set by any load and lt_done by any latch. Both clear in a cycle with stat_rd, unless a new event of their kind happens in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_up | input | 1 | Up strobe from the direction decoder |
| cnt_dn | input | 1 | Down strobe from the direction decoder |
| casc_en | input | 1 | Count the cascade inputs instead of the decoder strobes |
| casc_up_in | input | 1 | Carry from the lower unit |
| casc_dn_in | input | 1 | Borrow from the lower unit |
| abn_evt | input | 1 | Abnormal-input pulse from the decoder |
| quad_mode | input | 1 | 1 when the channel takes quadrature input |
| ph0 | input | 1 | Synchronized first phase |
| ph1 | input | 1 | Synchronized second phase |
| ld_pin | input | 1 | External load pin (acts on a falling edge) |
| ld_pin_en | input | 1 | Enable for ld_pin |
| lt_pin | input | 1 | External latch pin (acts on a rising edge) |
| lt_pin_en | input | 1 | Enable for lt_pin |
| clr_pin | input | 1 | External clear pin |
| clr_sync | input | 1 | 0 edge-style clear, 1 index-style clear |
| clr_policy | input | 2 | Clear policy code |
| policy_wr | input | 1 | Pulse when the policy is rewritten (re-arms once mode) |
| preload_wr | input | 1 | Write strobe for the preload register |
| preload_data | input | 16 | Preload write data |
| sw_load | input | 1 | Software load command |
| sw_latch | input | 1 | Software latch command |
| evt_rst | input | 4 | Write-one-to-clear bits for evt_flags |
| stat_rd | input | 1 | Status-read strobe |
| count | output | 16 | Counter value |
| latch_q | output | 16 | Captured counter value |
| evt_flags | output | 4 | Sticky event flags |
| ld_done | output | 1 | Load completed since last status read |
| lt_done | output | 1 | Latch completed since last status read |
| carry_out | output | 1 | Wrap from FFFFh on an up step |
| borrow_out | output | 1 | Wrap from 0000h on a down step |

## Verification
The properties assume that every input is already synchronous to clk. They also assume that ph0 and the three pins sit at their idle levels when reset releases. Those levels are low for ph0 and ld_pin, and either level for lt_pin and clr_pin. The unit therefore sees no false edge in its first cycle. The stimulus keeps policy_wr away from cycles that carry a clear event, so the once-policy re-arm is never racing a clear. Each strobe is applied for a single cycle, and each pin edge is spaced at least one idle cycle from the next.

// File: rtl/updown_pkg.sv
`timescale 1ns/1ps
package updown_pkg;
  typedef enum logic [1:0] {
    POL_NOP   = 2'b00,
    POL_OFF   = 2'b01,
    POL_ONCE  = 2'b10,
    POL_EVERY = 2'b11
  } clr_pol_e;

  localparam int unsigned EV_LOAD  = 0;
  localparam int unsigned EV_LATCH = 1;
  localparam int unsigned EV_CLEAR = 2;
  localparam int unsigned EV_ABN   = 3;
  localparam int unsigned EV_NUM   = 4;
endpackage

// File: rtl/updown_edge.sv
`timescale 1ns/1ps
module updown_edge #(
  parameter bit FALLING = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic en,
  output logic evt
);
  // idle level for the previous sample so reset never fakes an edge
  localparam logic IDLE = FALLING ? 1'b0 : 1'b1;

  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= IDLE;
    else        prev_q <= pin;
  end

  always_comb begin
    if (FALLING) evt = en & prev_q & ~pin;
    else         evt = en & ~prev_q & pin;
  end
endmodule

// File: rtl/updown_clear.sv
`timescale 1ns/1ps
module updown_clear
  import updown_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr_pin,
  input  logic       sync_mode,
  input  logic       quad_mode,
  input  logic       ph0,
  input  logic       ph1,
  input  logic [1:0] policy,
  input  logic       policy_wr,
  output logic       fire
);
  logic clr_prev_q, ph0_prev_q, armed_q;
  logic armed_d, evt, allow;

  always_comb begin
    if (sync_mode) evt = quad_mode & clr_pin & ~ph1 & (ph0 ^ ph0_prev_q);
    else           evt = clr_pin & ~clr_prev_q;
    allow = (policy == POL_EVERY) | ((policy == POL_ONCE) & armed_q);
    fire  = evt & allow;
    armed_d = armed_q;
    if (policy_wr)                       armed_d = 1'b1;
    else if (fire && policy == POL_ONCE) armed_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clr_prev_q <= 1'b1;
      ph0_prev_q <= 1'b0;
      armed_q    <= 1'b1;
    end else begin
      clr_prev_q <= clr_pin;
      ph0_prev_q <= ph0;
      armed_q    <= armed_d;
    end
  end

  // R8: a single clear under the once policy blocks the next one
  p_single_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && policy == POL_ONCE && !policy_wr) |=> (!fire || policy != POL_ONCE));
endmodule

// File: rtl/updown_flags.sv
`timescale 1ns/1ps
module updown_flags #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] wipe,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic d, en;
    always_comb begin
      en = set[i] | wipe[i];
      d  = set[i];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q[i] <= 1'b0;
      else if (en) q[i] <= d;
    end

    // R10: a flag stays up until its wipe bit is written
    p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (q[i] && !wipe[i]) |=> q[i]);
    // R10: a new event is never lost to a coincident wipe
    p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
      set[i] |=> q[i]);
  end
endmodule

// File: rtl/updown_unit.sv
`timescale 1ns/1ps
module updown_unit
  import updown_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_up,
  input  logic         cnt_dn,
  input  logic         casc_en,
  input  logic         casc_up_in,
  input  logic         casc_dn_in,
  input  logic         abn_evt,
  input  logic         quad_mode,
  input  logic         ph0,
  input  logic         ph1,
  input  logic         ld_pin,
  input  logic         ld_pin_en,
  input  logic         lt_pin,
  input  logic         lt_pin_en,
  input  logic         clr_pin,
  input  logic         clr_sync,
  input  logic [1:0]   clr_policy,
  input  logic         policy_wr,
  input  logic         preload_wr,
  input  logic [W-1:0] preload_data,
  input  logic         sw_load,
  input  logic         sw_latch,
  input  logic [3:0]   evt_rst,
  input  logic         stat_rd,
  output logic [W-1:0] count,
  output logic [W-1:0] latch_q,
  output logic [3:0]   evt_flags,
  output logic         ld_done,
  output logic         lt_done,
  output logic         carry_out,
  output logic         borrow_out
);
  localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};
  localparam logic [W-1:0] ZERO = '0;
  localparam logic [W-1:0] TOP  = '1;

  logic ld_edge, lt_edge, clr_fire;
  logic load_fire, latch_fire;
  logic up_s, dn_s, step_up, step_dn;
  logic cnt_en;
  logic [W-1:0] cnt_d, preload_q;
  logic [EV_NUM-1:0] ev_set;
  logic [1:0] done_q;

  updown_edge #(.FALLING(1'b1)) u_ld_edge (
    .clk(clk), .rst_n(rst_n), .pin(ld_pin), .en(ld_pin_en), .evt(ld_edge));
  updown_edge #(.FALLING(1'b0)) u_lt_edge (
    .clk(clk), .rst_n(rst_n), .pin(lt_pin), .en(lt_pin_en), .evt(lt_edge));

  updown_clear u_clear (
    .clk(clk), .rst_n(rst_n), .clr_pin(clr_pin), .sync_mode(clr_sync),
    .quad_mode(quad_mode), .ph0(ph0), .ph1(ph1), .policy(clr_policy),
    .policy_wr(policy_wr), .fire(clr_fire));

  // next-state for the count path: clear, then load, then step
  always_comb begin
    load_fire  = ld_edge | sw_load;
    latch_fire = lt_edge | sw_latch;
    up_s    = casc_en ? casc_up_in : cnt_up;
    dn_s    = casc_en ? casc_dn_in : cnt_dn;
    step_up = up_s & ~dn_s & ~clr_fire & ~load_fire;
    step_dn = dn_s & ~up_s & ~clr_fire & ~load_fire;
    carry_out  = step_up & (count == TOP);
    borrow_out = step_dn & (count == ZERO);
    cnt_en = clr_fire | load_fire | step_up | step_dn;
    if (clr_fire)       cnt_d = ZERO;
    else if (load_fire) cnt_d = preload_q;
    else if (step_up)   cnt_d = count + ONE;
    else                cnt_d = count - ONE;
    ev_set = '0;
    ev_set[EV_LOAD]  = load_fire;
    ev_set[EV_LATCH] = latch_fire;
    ev_set[EV_CLEAR] = clr_fire;
    ev_set[EV_ABN]   = abn_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count <= ZERO;
    else if (cnt_en) count <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          preload_q <= ZERO;
    else if (preload_wr) preload_q <= preload_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          latch_q <= ZERO;
    else if (latch_fire) latch_q <= count;
  end

  updown_flags #(.N(EV_NUM)) u_evt_flags (
    .clk(clk), .rst_n(rst_n), .set(ev_set), .wipe(evt_rst), .q(evt_flags));

  updown_flags #(.N(2)) u_done_flags (
    .clk(clk), .rst_n(rst_n), .set({latch_fire, load_fire}),
    .wipe({stat_rd, stat_rd}), .q(done_q));

  always_comb begin
    ld_done = done_q[0];
    lt_done = done_q[1];
  end

  // R6/R7/R8: any performed clear leaves the counter at zero
  p_clear_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_fire |=> count == ZERO);
  // R4/R9: a load not overridden by a clear takes the staged value
  p_load_value_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (load_fire && !clr_fire) |=> count == $past(preload_q));
  // R5: capture sees the pre-update count
  p_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
    latch_fire |=> latch_q == $past(count));
  // R3: wrap flags predict the wrapped value
  p_carry_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    carry_out |=> count == ZERO);
  p_borrow_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    borrow_out |=> count == TOP);
  // R2: lone up step advances by one
  p_step_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (up_s && !dn_s && !clr_fire && !load_fire) |=> count == $past(count) + ONE);
  // R11: a status read drops the done flag unless a new latch lands
  p_done_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !latch_fire) |=> !lt_done);
endmodule

// File: tb/tb_updown_unit.sv
`timescale 1ns/1ps
module tb_updown_unit;
  logic clk, rst_n;
  logic cnt_up, cnt_dn, casc_en, casc_up_in, casc_dn_in, abn_evt;
  logic quad_mode, ph0, ph1, ld_pin, ld_pin_en, lt_pin, lt_pin_en;
  logic clr_pin, clr_sync, policy_wr, preload_wr, sw_load, sw_latch, stat_rd;
  logic [1:0]  clr_policy;
  logic [15:0] preload_data;
  logic [3:0]  evt_rst;
  logic [15:0] count, latch_q;
  logic [3:0]  evt_flags;
  logic ld_done, lt_done, carry_out, borrow_out;

  int checks = 0;
  int errors = 0;

  typedef struct {
    string       tag;
    logic [15:0] c;
    logic [15:0] l;
    logic [3:0]  f;
    logic        ld;
    logic        lt;
  } exp_t;
  exp_t sbq[$];

  // reference state kept from the requirements
  logic [15:0] m_cnt, m_lat, m_pre;
  logic [3:0]  m_flags;
  logic m_ldd, m_ltd, m_armed, m_pld, m_plt, m_pclr, m_pph0;

  updown_unit dut (
    .clk(clk), .rst_n(rst_n), .cnt_up(cnt_up), .cnt_dn(cnt_dn),
    .casc_en(casc_en), .casc_up_in(casc_up_in), .casc_dn_in(casc_dn_in),
    .abn_evt(abn_evt), .quad_mode(quad_mode), .ph0(ph0), .ph1(ph1),
    .ld_pin(ld_pin), .ld_pin_en(ld_pin_en), .lt_pin(lt_pin), .lt_pin_en(lt_pin_en),
    .clr_pin(clr_pin), .clr_sync(clr_sync), .clr_policy(clr_policy),
    .policy_wr(policy_wr), .preload_wr(preload_wr), .preload_data(preload_data),
    .sw_load(sw_load), .sw_latch(sw_latch), .evt_rst(evt_rst), .stat_rd(stat_rd),
    .count(count), .latch_q(latch_q), .evt_flags(evt_flags),
    .ld_done(ld_done), .lt_done(lt_done), .carry_out(carry_out), .borrow_out(borrow_out));

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // monitor: pop one expected item per cycle and compare
  always @(negedge clk) begin
    exp_t e;
    if (sbq.size() != 0) begin
      e = sbq.pop_front();
      chk(e.tag, "count", count, e.c);
      chk(e.tag, "latch_q", latch_q, e.l);
      chk(e.tag, "evt_flags", {12'h0, evt_flags}, {12'h0, e.f});
      chk(e.tag, "ld_done", {15'h0, ld_done}, {15'h0, e.ld});
      chk(e.tag, "lt_done", {15'h0, lt_done}, {15'h0, e.lt});
    end
  end

  // driver: one clock of stimulus, expected result pushed to the scoreboard
  task automatic cyc(input string tag);
    logic ld_e, lt_e, ce, cf, lf, ltf, up_s, dn_s, su, sd, allow, ec, eb;
    ld_e = ld_pin_en && m_pld && !ld_pin;
    lt_e = lt_pin_en && !m_plt && lt_pin;
    if (clr_sync) ce = quad_mode && clr_pin && !ph1 && (ph0 != m_pph0);
    else          ce = clr_pin && !m_pclr;
    allow = (clr_policy == 2'b11) || (clr_policy == 2'b10 && m_armed);
    cf  = ce && allow;
    lf  = ld_e || sw_load;
    ltf = lt_e || sw_latch;
    up_s = casc_en ? casc_up_in : cnt_up;
    dn_s = casc_en ? casc_dn_in : cnt_dn;
    su = up_s && !dn_s && !cf && !lf;
    sd = dn_s && !up_s && !cf && !lf;
    ec = su && (m_cnt == 16'hFFFF);
    eb = sd && (m_cnt == 16'h0000);
    #1;
    chk("R3", "carry_out", {15'h0, carry_out}, {15'h0, ec});
    chk("R3", "borrow_out", {15'h0, borrow_out}, {15'h0, eb});
    @(posedge clk);
    if (ltf) m_lat = m_cnt;
    if (cf)      m_cnt = 16'h0;
    else if (lf) m_cnt = m_pre;
    else if (su) m_cnt = m_cnt + 16'h1;
    else if (sd) m_cnt = m_cnt - 16'h1;
    if (preload_wr) m_pre = preload_data;
    m_flags = (m_flags & ~evt_rst) | {abn_evt, cf, ltf, lf};
    m_ldd = (m_ldd && !stat_rd) || lf;
    m_ltd = (m_ltd && !stat_rd) || ltf;
    if (policy_wr)                      m_armed = 1'b1;
    else if (cf && clr_policy == 2'b10) m_armed = 1'b0;
    m_pld = ld_pin; m_plt = lt_pin; m_pclr = clr_pin; m_pph0 = ph0;
    sbq.push_back('{tag, m_cnt, m_lat, m_flags, m_ldd, m_ltd});
    @(negedge clk);
    sw_load = 0; sw_latch = 0; preload_wr = 0; policy_wr = 0;
    evt_rst = 4'h0; stat_rd = 0; abn_evt = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0;
    cnt_up = 0; cnt_dn = 0; casc_en = 0; casc_up_in = 0; casc_dn_in = 0; abn_evt = 0;
    quad_mode = 0; ph0 = 0; ph1 = 0; ld_pin = 0; ld_pin_en = 0; lt_pin = 0; lt_pin_en = 0;
    clr_pin = 0; clr_sync = 0; clr_policy = 2'b11; policy_wr = 0; preload_wr = 0;
    preload_data = 16'h0; sw_load = 0; sw_latch = 0; evt_rst = 4'h0; stat_rd = 0;
    m_cnt = 0; m_lat = 0; m_pre = 0; m_flags = 0; m_ldd = 0; m_ltd = 0; m_armed = 1;
    m_pld = 0; m_plt = 1; m_pclr = 1; m_pph0 = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1", "count", count, 16'h0);
    chk("R1", "latch_q", latch_q, 16'h0);
    chk("R1", "flags", {10'h0, evt_flags, ld_done, lt_done}, 16'h0);
    rst_n = 1;
    cyc("R1");

    // R2: steps, both-at-once, cascade source
    cnt_up = 1; repeat (3) cyc("R2");
    cnt_up = 0; cnt_dn = 1; cyc("R2");
    cnt_up = 1; cyc("R2");
    cnt_up = 0; cnt_dn = 0;
    casc_en = 1; casc_up_in = 1; cnt_dn = 1; cyc("R2");
    casc_up_in = 0; casc_dn_in = 1; cnt_dn = 0; cnt_up = 1; cyc("R2");
    casc_dn_in = 0; cnt_up = 0; casc_en = 0;

    // R3: wrap both ways
    preload_wr = 1; preload_data = 16'hFFFF; cyc("R3");
    sw_load = 1; cyc("R4");
    cnt_up = 1; cyc("R3");
    cnt_up = 0; cnt_dn = 1; cyc("R3");
    cnt_dn = 0;

    // R4: pin load enabled and disabled
    preload_wr = 1; preload_data = 16'h1234; cyc("R4");
    ld_pin_en = 1; ld_pin = 1; cyc("R4");
    ld_pin = 0; cyc("R4");
    ld_pin_en = 0; cnt_up = 1; preload_wr = 1; preload_data = 16'h0055; cyc("R4");
    cnt_up = 0; ld_pin = 1; cyc("R4");
    ld_pin = 0; cyc("R4");

    // R5: capture by pin and command, pre-update value
    lt_pin_en = 1; lt_pin = 1; cyc("R5");
    cnt_up = 1; sw_latch = 1; cyc("R5");
    cnt_up = 0; lt_pin = 0; cyc("R5");
    lt_pin_en = 0; lt_pin = 1; cyc("R5");
    lt_pin = 0;

    // R11: read clears done flags, new event in the same cycle wins
    stat_rd = 1; cyc("R11");
    stat_rd = 1; sw_load = 1; cyc("R11");
    stat_rd = 1; cyc("R11");

    // R10: abnormal flag and write-one-to-clear
    abn_evt = 1; cyc("R10");
    evt_rst = 4'b0001; cyc("R10");
    evt_rst = 4'b1110; sw_latch = 1; cyc("R10");
    evt_rst = 4'b1111; cyc("R10");

    // R6: edge-style clear, held level does not repeat
    cnt_up = 1; cyc("R6");
    clr_pin = 1; cyc("R6");
    cyc("R6"); cyc("R6");
    cnt_up = 0; clr_pin = 0; cyc("R6");

    // R8: once, re-arm, disabled codes
    clr_policy = 2'b10; policy_wr = 1; cnt_up = 1; cyc("R8");
    cnt_up = 0; clr_pin = 1; cyc("R8");
    clr_pin = 0; cnt_up = 1; cyc("R8"); cyc("R8");
    cnt_up = 0; clr_pin = 1; cyc("R8");
    clr_pin = 0; policy_wr = 1; cyc("R8");
    clr_pin = 1; cyc("R8");
    clr_pin = 0; clr_policy = 2'b01; policy_wr = 1; cnt_up = 1; cyc("R8");
    cnt_up = 0; clr_pin = 1; cyc("R8");
    clr_pin = 0; clr_policy = 2'b00; policy_wr = 1; cyc("R8");
    clr_pin = 1; cyc("R8");
    clr_pin = 0; clr_policy = 2'b11; policy_wr = 1; cyc("R8");

    // R7: index-style clear
    clr_sync = 1; quad_mode = 1; cnt_up = 1; cyc("R7");
    cnt_up = 0; clr_pin = 1; cyc("R7");
    ph0 = 1; cyc("R7");
    cnt_up = 1; ph1 = 1; cyc("R7");
    cnt_up = 0; ph0 = 0; cyc("R7");
    ph1 = 0; quad_mode = 0; ph0 = 1; cyc("R7");
    clr_pin = 0; clr_sync = 0; ph0 = 0; cyc("R7");

    // R9: priority
    preload_wr = 1; preload_data = 16'h0777; cyc("R9");
    cnt_up = 1; sw_load = 1; clr_pin = 1; cyc("R9");
    clr_pin = 0; sw_load = 1; cyc("R9");
    cnt_up = 0; cyc("R9");

    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule